// File: doc/BRIEF.md
# Sample FIFO with Trigger Notification

This block holds 12-bit conversion results in a small first-in first-out buffer until a host pops them. Each incoming sample arrives with a valid strobe; each host read arrives as a one-cycle pop strobe and loads the oldest stored sample into a registered read-data output. A host-facing notification line tells the processor when enough samples are waiting. The fill level that counts as enough is chosen with a 2-bit threshold code. The line can be a level or a one-clock pulse, and it can be active high or active low.

Samples that arrive while the buffer is full are dropped. Each drop raises a one-cycle overflow event and sets a sticky overflow flag, which the host clears with a clear strobe. A flush command empties the buffer without a device reset. After a device reset, a short hold-off discards incoming samples while the converter settles.

Top module: `smp_fifo_notify`

## Requirements
- R1: While reset is held and on the first cycle after it: read data is 0, the fill level is 0, the overflow event and the sticky flag are 0, and the notification line is inactive.
- R2: Samples are returned in arrival order. An accepted pop updates read data on that clock edge, and read data then holds until the next accepted pop. A push and a pop on the same edge are both honoured.
- R3: A pop while the buffer is empty leaves read data unchanged and moves no pointer. Later samples still come out in order.
- R4: Samples presented on the first 5 rising edges after reset is released are discarded. The sample on the 6th edge is stored.
- R5: Threshold codes 00, 01, 10 and 11 select fill levels of 1, 4, 8 and 14 samples. In level mode (pulse input 0), the line is active while the fill level is at or above the selected level.
- R6: In pulse mode (pulse input 1), the line is active for exactly one clock each time the fill level rises from below the selected level to at or above it. It stays inactive while the level remains there.
- R7: With the polarity input at 1, active means the line is 1. With it at 0, active means 0 and inactive means 1.
- R8: A valid sample that arrives while 16 samples are stored is dropped, and the stored contents are not changed. The overflow event is 1 for exactly the one cycle after that edge.
- R9: The sticky overflow flag is set together with the overflow event and holds until the clear strobe. When a set and a clear land on the same edge, the set wins. Reset clears the flag.
- R10: A flush empties the buffer, which returns the notification line to inactive. A flush takes priority over a push or pop on the same edge. It does not change read data or the sticky flag.
- R11: The buffer holds exactly 16 samples without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high device reset |
| flush_i | input | 1 | Empty the buffer |
| smp_vld_i | input | 1 | Sample valid strobe |
| smp_data_i | input | 12 | Sample value |
| pop_i | input | 1 | Host pop strobe |
| trig_sel_i | input | 2 | Threshold code |
| notify_pulse_i | input | 1 | 1 selects pulse mode, 0 selects level mode |
| notify_hi_i | input | 1 | 1 selects active high, 0 selects active low |
| ovf_clr_i | input | 1 | Clear strobe for the sticky overflow flag |
| rd_data_o | output | 12 | Last popped sample |
| avail_o | output | 1 | Data-available notification |
| ovf_evt_o | output | 1 | One-cycle overflow event |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The threshold compare is exercised by filling one sample at a time under each of the four codes and checking the line after every push. This separates a wrong level from an off-by-one at the boundary. Pulse mode is tried on a rise, on a hold above the level, and on a drop below and climb back. These show that the pulse is one clock long and that it re-arms. Both polarities are tried in both modes, which catches an inversion applied to the wrong stage. Ordering is checked with a full 16-sample fill, with a simultaneous push and pop, and with pops past empty. Overflow is checked with a write into a full buffer followed by a full drain, which proves the dropped sample never entered the buffer.

// File: rtl/smpfifo_pkg.sv
package smpfifo_pkg;

    localparam int unsigned SMP_W_DEF   = 12;
    localparam int unsigned DEPTH_DEF   = 16;
    localparam int unsigned HOLDOFF_DEF = 5;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_QUARTER  = 2'b01,
        TRIG_HALF     = 2'b10,
        TRIG_NEARFULL = 2'b11
    } trig_sel_e;

    typedef struct packed {
        trig_sel_e sel;
        logic      pulse;
        logic      act_hi;
    } notify_cfg_t;

    // fill level that makes the notification active for a given code
    function automatic int unsigned trig_level(trig_sel_e sel, int unsigned depth);
        int unsigned lvl;
        case (sel)
            TRIG_ONE:     lvl = 1;
            TRIG_QUARTER: lvl = depth / 4;
            TRIG_HALF:    lvl = depth / 2;
            default:      lvl = (depth > 2) ? depth - 2 : depth;
        endcase
        if (lvl == 0) lvl = 1;
        return lvl;
    endfunction

    function automatic int unsigned cnt_width(int unsigned depth);
        return $clog2(depth + 1);
    endfunction

    function automatic int unsigned ptr_width(int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic bit is_pow2(int unsigned depth);
        return (depth > 1) && ((depth & (depth - 1)) == 0);
    endfunction

endpackage

// File: rtl/smpfifo_holdoff.sv
module smpfifo_holdoff #(
    parameter int unsigned HOLDOFF = smpfifo_pkg::HOLDOFF_DEF
) (
    input  logic clk,
    input  logic rst,
    output logic ready_o
);
    localparam int unsigned HW = (HOLDOFF > 0) ? $clog2(HOLDOFF + 1) : 1;

    logic [HW-1:0] wait_cnt;

    assign ready_o = (wait_cnt == HW'(HOLDOFF));

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_cnt <= '0;
        end else if (!ready_o) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/smpfifo_store.sv
module smpfifo_store #(
    parameter int unsigned SMP_W = smpfifo_pkg::SMP_W_DEF,
    parameter int unsigned DEPTH = smpfifo_pkg::DEPTH_DEF,
    localparam int unsigned CNT_W = smpfifo_pkg::cnt_width(DEPTH),
    localparam int unsigned PTR_W = smpfifo_pkg::ptr_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic [SMP_W-1:0] wdata_i,
    input  logic             pop_i,
    output logic [SMP_W-1:0] rdata_o,
    output logic [CNT_W-1:0] count_o,
    output logic             drop_o
);
    logic [SMP_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic             full, empty, wr_en, rd_en;

    assign full   = (count_o == CNT_W'(DEPTH));
    assign empty  = (count_o == '0);
    assign wr_en  = push_i & ~flush_i & ~full;
    assign rd_en  = pop_i  & ~flush_i & ~empty;
    assign drop_o = push_i & ~flush_i & full;

    generate
        if (smpfifo_pkg::is_pow2(DEPTH)) begin : g_wrap_free
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap_cmp
            assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_o <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_nxt;
            if (rd_en) rd_ptr <= rd_nxt;
            case ({wr_en, rd_en})
                2'b10:   count_o <= count_o + 1'b1;
                2'b01:   count_o <= count_o - 1'b1;
                default: count_o <= count_o;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
        end else if (rd_en) begin
            rdata_o <= mem[rd_ptr];
        end
    end
endmodule

// File: rtl/smpfifo_notify.sv
module smpfifo_notify #(
    parameter int unsigned DEPTH = smpfifo_pkg::DEPTH_DEF,
    localparam int unsigned CNT_W = smpfifo_pkg::cnt_width(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  smpfifo_pkg::notify_cfg_t cfg_i,
    input  logic [CNT_W-1:0]         count_i,
    output logic                     avail_o
);
    logic [CNT_W-1:0] thr_lvl;
    logic             reached, reached_q, active;

    always_comb begin
        thr_lvl = CNT_W'(smpfifo_pkg::trig_level(cfg_i.sel, DEPTH));
        reached = (count_i >= thr_lvl);
        active  = cfg_i.pulse ? (reached & ~reached_q) : reached;
        avail_o = cfg_i.act_hi ? active : ~active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reached_q <= 1'b0;
        end else begin
            reached_q <= reached;
        end
    end
endmodule

// File: rtl/smp_fifo_notify.sv
module smp_fifo_notify #(
    parameter int unsigned SMP_W   = smpfifo_pkg::SMP_W_DEF,
    parameter int unsigned DEPTH   = smpfifo_pkg::DEPTH_DEF,
    parameter int unsigned HOLDOFF = smpfifo_pkg::HOLDOFF_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic             smp_vld_i,
    input  logic [SMP_W-1:0] smp_data_i,
    input  logic             pop_i,
    input  logic [1:0]       trig_sel_i,
    input  logic             notify_pulse_i,
    input  logic             notify_hi_i,
    input  logic             ovf_clr_i,
    output logic [SMP_W-1:0] rd_data_o,
    output logic             avail_o,
    output logic             ovf_evt_o,
    output logic             ovf_flag_o
);
    localparam int unsigned CNT_W = smpfifo_pkg::cnt_width(DEPTH);

    smpfifo_pkg::notify_cfg_t cfg;
    logic [CNT_W-1:0]         fill_cnt;
    logic                     accept_ok, drop;

    assign cfg.sel    = smpfifo_pkg::trig_sel_e'(trig_sel_i);
    assign cfg.pulse  = notify_pulse_i;
    assign cfg.act_hi = notify_hi_i;

    smpfifo_holdoff #(.HOLDOFF(HOLDOFF)) holdoff_i (
        .clk     (clk),
        .rst     (rst),
        .ready_o (accept_ok)
    );

    smpfifo_store #(.SMP_W(SMP_W), .DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .rst     (rst),
        .flush_i (flush_i),
        .push_i  (smp_vld_i & accept_ok),
        .wdata_i (smp_data_i),
        .pop_i   (pop_i),
        .rdata_o (rd_data_o),
        .count_o (fill_cnt),
        .drop_o  (drop)
    );

    smpfifo_notify #(.DEPTH(DEPTH)) notify_i (
        .clk     (clk),
        .rst     (rst),
        .cfg_i   (cfg),
        .count_i (fill_cnt),
        .avail_o (avail_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_evt_o  <= 1'b0;
            ovf_flag_o <= 1'b0;
        end else begin
            ovf_evt_o <= drop;
            if (drop)           ovf_flag_o <= 1'b1;
            else if (ovf_clr_i) ovf_flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/smpfifo_chk.sv
module smpfifo_chk #(
    parameter int unsigned SMP_W = smpfifo_pkg::SMP_W_DEF,
    parameter int unsigned DEPTH = smpfifo_pkg::DEPTH_DEF,
    localparam int unsigned CNT_W = smpfifo_pkg::cnt_width(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             flush_i,
    input logic             pop_i,
    input logic             ovf_clr_i,
    input logic             notify_pulse_i,
    input logic             notify_hi_i,
    input logic [SMP_W-1:0] rd_data_o,
    input logic             avail_o,
    input logic             ovf_evt_o,
    input logic             ovf_flag_o,
    input logic [CNT_W-1:0] fill_cnt
);
    // R11
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= CNT_W'(DEPTH));

    // R3
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_i && fill_cnt == '0) |=> $stable(rd_data_o));

    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        (notify_pulse_i && notify_hi_i && $past(notify_pulse_i && notify_hi_i && avail_o))
        |-> !avail_o);

    // R8
    ovf_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_evt_o |-> ($past(fill_cnt) == CNT_W'(DEPTH)));

    // R9
    ovf_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_evt_o |-> ovf_flag_o);

    // R9
    ovf_flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o);

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (fill_cnt == '0));
endmodule

bind smp_fifo_notify smpfifo_chk #(.SMP_W(SMP_W), .DEPTH(DEPTH)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .flush_i        (flush_i),
    .pop_i          (pop_i),
    .ovf_clr_i      (ovf_clr_i),
    .notify_pulse_i (notify_pulse_i),
    .notify_hi_i    (notify_hi_i),
    .rd_data_o      (rd_data_o),
    .avail_o        (avail_o),
    .ovf_evt_o      (ovf_evt_o),
    .ovf_flag_o     (ovf_flag_o),
    .fill_cnt       (fill_cnt)
);

// File: tb/smp_fifo_notify_tb_top.sv
module smp_fifo_notify_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        vld = 1'b0;
    logic [11:0] din = '0;
    logic        pop = 1'b0;
    logic [1:0]  tsel = 2'b00;
    logic        pmode = 1'b0;
    logic        hi = 1'b1;
    logic        oclr = 1'b0;
    logic [11:0] rd_data;
    logic        avail, ovf_evt, ovf_flag;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    smp_fifo_notify dut_i (
        .clk            (clk),
        .rst            (rst),
        .flush_i        (flush),
        .smp_vld_i      (vld),
        .smp_data_i     (din),
        .pop_i          (pop),
        .trig_sel_i     (tsel),
        .notify_pulse_i (pmode),
        .notify_hi_i    (hi),
        .ovf_clr_i      (oclr),
        .rd_data_o      (rd_data),
        .avail_o        (avail),
        .ovf_evt_o      (ovf_evt),
        .ovf_flag_o     (ovf_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(input logic [11:0] d);
        vld = 1'b1; din = d;
        tick();
        vld = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [11:0] exp);
        pop = 1'b1;
        tick();
        pop = 1'b0;
        chk(req, int'(rd_data), int'(exp));
    endtask

    task automatic do_flush();
        flush = 1'b1;
        tick();
        flush = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        hi = 1'b1; pmode = 1'b0; tsel = 2'b00;
        tick();
        tick();
        chk("R1 rd_data in reset", int'(rd_data), 0);
        chk("R1 avail in reset", int'(avail), 0);
        chk("R1 ovf_evt in reset", int'(ovf_evt), 0);
        chk("R1 ovf_flag in reset", int'(ovf_flag), 0);
    endtask

    task automatic t_holdoff();
        do_reset();
        for (int i = 1; i <= 7; i++) begin
            push(12'h100 + 12'(i));
            if (i == 5) chk("R4 nothing stored in hold-off", int'(avail), 0);
            if (i == 6) chk("R4 sixth edge stored", int'(avail), 1);
        end
        pop_expect("R4 first kept sample", 12'h106);
        pop_expect("R2 second kept sample", 12'h107);
        pop_expect("R3 pop on empty holds", 12'h107);
        chk("R3 empty after drain", int'(avail), 0);
    endtask

    task automatic t_order();
        for (int i = 0; i < 16; i++) push(12'h400 + 12'(i));
        chk("R11 sixteen fit without overflow", int'(ovf_evt), 0);
        chk("R11 no sticky flag", int'(ovf_flag), 0);
        for (int i = 0; i < 16; i++) pop_expect("R2 arrival order", 12'h400 + 12'(i));
        push(12'h501);
        vld = 1'b1; din = 12'h502; pop = 1'b1;
        tick();
        vld = 1'b0; pop = 1'b0;
        chk("R2 push and pop together", int'(rd_data), 12'h501);
        pop_expect("R2 sample pushed during pop", 12'h502);
        pop_expect("R3 stays after extra pop", 12'h502);
        push(12'h503);
        pop_expect("R3 pointers unmoved by empty pop", 12'h503);
    endtask

    task automatic t_levels();
        int thr [4] = '{1, 4, 8, 14};
        hi = 1'b1; pmode = 1'b0;
        for (int c = 0; c < 4; c++) begin
            tsel = 2'(c);
            do_flush();
            chk("R5 inactive when empty", int'(avail), 0);
            for (int n = 1; n <= 15; n++) begin
                push(12'h600 + 12'(n));
                chk($sformatf("R5 code %0d level %0d", c, n), int'(avail),
                    (n >= thr[c]) ? 1 : 0);
            end
        end
        do_flush();
    endtask

    task automatic t_pulse();
        hi = 1'b1; pmode = 1'b1; tsel = 2'b01;
        do_flush();
        for (int n = 1; n <= 3; n++) begin
            push(12'h300 + 12'(n));
            chk("R6 below level", int'(avail), 0);
        end
        push(12'h304);
        chk("R6 pulse on reaching level", int'(avail), 1);
        tick();
        chk("R6 pulse is one clock", int'(avail), 0);
        push(12'h305);
        chk("R6 no pulse above level", int'(avail), 0);
        pop_expect("R6 drain one", 12'h301);
        chk("R6 still at level no pulse", int'(avail), 0);
        pop_expect("R6 drain two", 12'h302);
        chk("R6 below level after drain", int'(avail), 0);
        push(12'h306);
        chk("R6 pulse re-arms", int'(avail), 1);
        tick();
        chk("R6 re-armed pulse one clock", int'(avail), 0);
        do_flush();
    endtask

    task automatic t_polarity();
        hi = 1'b0; pmode = 1'b0; tsel = 2'b00;
        do_flush();
        chk("R7 low-active idle is 1", int'(avail), 1);
        push(12'h701);
        chk("R7 low-active level is 0", int'(avail), 0);
        tick();
        chk("R7 low-active level holds", int'(avail), 0);
        pop_expect("R7 drain", 12'h701);
        chk("R7 low-active back to 1", int'(avail), 1);
        pmode = 1'b1;
        tick();
        push(12'h702);
        chk("R7 low-active pulse is 0", int'(avail), 0);
        tick();
        chk("R7 low-active pulse ends", int'(avail), 1);
        hi = 1'b1; pmode = 1'b0;
        do_flush();
    endtask

    task automatic t_overflow();
        do_flush();
        for (int i = 0; i < 16; i++) push(12'h200 + 12'(i));
        chk("R8 no event at full", int'(ovf_evt), 0);
        push(12'hEEE);
        chk("R8 event after drop", int'(ovf_evt), 1);
        chk("R9 flag set with event", int'(ovf_flag), 1);
        tick();
        chk("R8 event one cycle", int'(ovf_evt), 0);
        chk("R9 flag sticky", int'(ovf_flag), 1);
        for (int i = 0; i < 16; i++) pop_expect("R8 contents intact", 12'h200 + 12'(i));
        pop_expect("R8 dropped sample absent", 12'h20F);
        oclr = 1'b1;
        tick();
        oclr = 1'b0;
        chk("R9 clear strobe", int'(ovf_flag), 0);
        for (int i = 0; i < 16; i++) push(12'h210 + 12'(i));
        vld = 1'b1; din = 12'hEEF; oclr = 1'b1;
        tick();
        vld = 1'b0; oclr = 1'b0;
        chk("R9 set wins over clear", int'(ovf_flag), 1);
        tick();
        chk("R9 flag held after", int'(ovf_flag), 1);
    endtask

    task automatic t_flush();
        hi = 1'b1; pmode = 1'b0; tsel = 2'b00;
        do_flush();
        chk("R10 flush clears level", int'(avail), 0);
        chk("R10 flush keeps flag", int'(ovf_flag), 1);
        chk("R10 flush keeps rd_data", int'(rd_data), 12'h20F);
        push(12'h0AB);
        pop_expect("R10 new head after flush", 12'h0AB);
        push(12'h0AC);
        flush = 1'b1; vld = 1'b1; din = 12'h0CD;
        tick();
        flush = 1'b0; vld = 1'b0;
        chk("R10 flush wins over push", int'(avail), 0);
        push(12'h0EF);
        pop_expect("R10 only post-flush sample", 12'h0EF);
        do_reset();
        chk("R9 reset clears flag", int'(ovf_flag), 0);
        chk("R1 read data after reset", int'(rd_data), 0);
        chk("R1 line inactive after reset", int'(avail), 0);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_holdoff();
        t_order();
        t_levels();
        t_pulse();
        t_polarity();
        t_overflow();
        t_flush();
        report();
        $finish;
    end

endmodule